// File: doc/BRIEF.md
# Snoop Protocol Reduction Wrapper

This block sits between a shared system bus and the snoop port of one processor's cache controller. It lets a processor whose invalidation-based protocol has more states than its neighbours work coherently beside them. It does this by changing how each observed bus transaction is shown to the local snooper, and by driving the local cache's shared-line input to a level chosen by the selected reduction. The memory side always receives the true transaction type.

A two-bit mode input picks the reduction. One mode collapses the local protocol to Modified/Exclusive/Invalid. One collapses it to Modified/Shared/Invalid. One reduces an owned-state protocol to MESI. The last passes transactions through unchanged. Snooped reads are misreported as writes where the mode needs it, so the local line is drained or invalidated and never demoted to a shared or owned copy. The shared input is forced low where the shared state must never be entered from a miss, and forced high where the exclusive state must never be entered. Transactions issued by this block's own processor are never shown to its own snooper. The mode is captured only in cycles with no snoop, so a change that arrives during a snoop applies from the next snoop. All outputs are registered with one cycle of latency.

Top module: `snoop_reduce_wrap`

## Requirements
- R1: While reset is high, and on the first cycle after it, local_snoop_valid, local_snoop_is_write, local_inv, local_shared, mem_valid and mem_is_write are all 0.
- R2: In mode 0 (reduce to MEI), a snooped read from another master is presented one cycle later with local_snoop_is_write=1 and local_inv=1.
- R3: In mode 0, local_shared is 0 in the cycle after miss_valid, whatever bus_shared is.
- R4: In mode 1 (reduce to MSI), local_shared is 1 in the cycle after miss_valid, whatever bus_shared is.
- R5: In mode 1, a snooped read is presented as a write with local_inv=1 when HAS_O_STATE=1, and as a read with local_inv=0 when HAS_O_STATE=0.
- R6: In mode 2 (owned-state protocol to MESI), a snooped read is presented as a write with local_inv=1, and local_shared in the cycle after miss_valid equals bus_shared from the miss cycle.
- R7: In mode 3 (no reduction), a snooped read is presented as a read with local_inv=0, and local_shared after a miss equals bus_shared.
- R8: In every mode, a snooped write from another master is presented with local_snoop_is_write=1 and local_inv=1.
- R9: One cycle after any bus transaction, whatever its source, mem_valid=1, mem_addr equals its address and mem_is_write equals its true type.
- R10: A snoop whose snoop_src equals LOCAL_ID gives local_snoop_valid=0, local_snoop_is_write=0 and local_inv=0 one cycle later.
- R11: The mode is taken from mode_i at reset and in every cycle with snoop_valid=0. A mode_i change during a cycle with snoop_valid=1 does not affect that snoop's presentation.
- R12: local_snoop_addr equals snoop_addr from the previous cycle. With no snoop or no miss, the valid, type, invalidate and shared outputs are 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Reduction select: 0 MEI, 1 MSI, 2 MESI, 3 none |
| snoop_valid | input | 1 | A bus transaction is observed this cycle |
| snoop_addr | input | ADDR_W | Bus transaction address |
| snoop_is_write | input | 1 | Bus transaction is a write |
| snoop_src | input | ID_W | Master that issued the bus transaction |
| bus_shared | input | 1 | Shared indication sensed on the bus |
| miss_valid | input | 1 | Local cache requests a shared response for its read miss |
| local_snoop_valid | output | 1 | Snoop presented to the local snooper |
| local_snoop_addr | output | ADDR_W | Address presented to the local snooper |
| local_snoop_is_write | output | 1 | Presented type (1 = write) |
| local_inv | output | 1 | Snoop-invalidate to the local cache |
| local_shared | output | 1 | Shared input returned to the local cache |
| mem_valid | output | 1 | Transaction forwarded to the memory side |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_is_write | output | 1 | Forwarded true type |

## Verification
Directed sequences drive reads, writes and misses in each of the four modes, once with bus_shared high and once with it low. This separates the forced shared levels of the MEI and MSI reductions from the pass-through of the other two. A second instance built without the owned state shows that the MSI reduction converts reads only when the owned state exists. Snoops from the block's own source identifier, and a mode change made during a snoop, show the self-filter and the mode capture rule. A long random stream then mixes modes, sources, types and misses. Every output is compared against a bench model of the rules, with its mode capture updated only on idle cycles.

// File: rtl/snoop_reduce_pkg.sv
package snoop_reduce_pkg;

  typedef enum logic [1:0] {
    RED_MEI    = 2'd0,
    RED_MSI    = 2'd1,
    RED_MESI   = 2'd2,
    RED_NATIVE = 2'd3
  } red_mode_e;

  // Forced level of the shared input in a reduction mode
  typedef struct packed {
    logic forced;   // 1: level is fixed by the mode
    logic level;    // fixed level when forced
  } shared_rule_t;

  function automatic shared_rule_t shared_rule(input red_mode_e m);
    shared_rule_t r;
    case (m)
      RED_MEI: begin r.forced = 1'b1; r.level = 1'b0; end
      RED_MSI: begin r.forced = 1'b1; r.level = 1'b1; end
      default: begin r.forced = 1'b0; r.level = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/snoop_mode_capture.sv
module snoop_mode_capture
  import snoop_reduce_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] mode_i,
  input  logic      snoop_busy,
  output red_mode_e mode_q
);

  // Mode is loaded at reset and on idle cycles only
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= red_mode_e'(mode_i);
    end else if (!snoop_busy) begin
      mode_q <= red_mode_e'(mode_i);
    end
  end

  AST_MODE_HELD_IN_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snoop_busy |=> $stable(mode_q)); // R11

endmodule

// File: rtl/snoop_presenter.sv
module snoop_presenter
  import snoop_reduce_pkg::*;
#(
  parameter int   ADDR_W      = 32,
  parameter int   ID_W        = 2,
  parameter logic [ID_W-1:0] LOCAL_ID = '0,
  parameter bit   HAS_O_STATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  red_mode_e         mode_q,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              snoop_is_write,
  input  logic [ID_W-1:0]   snoop_src,
  output logic              local_snoop_valid,
  output logic [ADDR_W-1:0] local_snoop_addr,
  output logic              local_snoop_is_write,
  output logic              local_inv
);

  logic msi_conv;
  logic rd_to_wr;
  logic foreign;
  logic shown_write;

  // In the MSI reduction only an owned-state cache needs the conversion
  generate
    if (HAS_O_STATE) begin : g_owned
      assign msi_conv = 1'b1;
    end else begin : g_plain
      assign msi_conv = 1'b0;
    end
  endgenerate

  always_comb begin
    case (mode_q)
      RED_MEI:  rd_to_wr = 1'b1;
      RED_MSI:  rd_to_wr = msi_conv;
      RED_MESI: rd_to_wr = 1'b1;
      default:  rd_to_wr = 1'b0;
    endcase
  end

  assign foreign     = snoop_valid && (snoop_src != LOCAL_ID);
  assign shown_write = snoop_is_write || rd_to_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      local_snoop_valid    <= 1'b0;
      local_snoop_addr     <= '0;
      local_snoop_is_write <= 1'b0;
      local_inv            <= 1'b0;
    end else begin
      local_snoop_valid    <= foreign;
      local_snoop_addr     <= snoop_addr;
      local_snoop_is_write <= foreign && shown_write;
      local_inv            <= foreign && shown_write;
    end
  end

  AST_WRITE_SHOWN_AS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_is_write && snoop_src != LOCAL_ID)
      |=> (local_snoop_is_write && local_inv)); // R8
  AST_OWN_NOT_SHOWN: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_src == LOCAL_ID)
      |=> (!local_snoop_valid && !local_inv)); // R10
  AST_MEI_READ_CONVERTED: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && !snoop_is_write && snoop_src != LOCAL_ID && mode_q == RED_MEI)
      |=> local_snoop_is_write); // R2
  AST_NATIVE_READ_KEPT: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && !snoop_is_write && mode_q == RED_NATIVE)
      |=> (!local_snoop_is_write && !local_inv)); // R7

endmodule

// File: rtl/shared_driver.sv
module shared_driver
  import snoop_reduce_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  red_mode_e mode_q,
  input  logic      miss_valid,
  input  logic      bus_shared,
  output logic      local_shared
);

  shared_rule_t rule;
  logic         level;

  assign rule  = shared_rule(mode_q);
  assign level = rule.forced ? rule.level : bus_shared;

  always_ff @(posedge clk) begin
    if (rst) local_shared <= 1'b0;
    else     local_shared <= miss_valid && level;
  end

  AST_MEI_NEVER_SHARED: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && mode_q == RED_MEI) |=> !local_shared); // R3
  AST_MSI_ALWAYS_SHARED: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && mode_q == RED_MSI) |=> local_shared); // R4
  AST_IDLE_NOT_SHARED: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |=> !local_shared); // R12

endmodule

// File: rtl/mem_forward.sv
module mem_forward #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              snoop_is_write,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_is_write
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid    <= 1'b0;
      mem_addr     <= '0;
      mem_is_write <= 1'b0;
    end else begin
      mem_valid    <= snoop_valid;
      mem_addr     <= snoop_addr;
      mem_is_write <= snoop_valid && snoop_is_write;
    end
  end

  AST_MEM_TRUE_TYPE: assert property (@(posedge clk) disable iff (rst)
    snoop_valid |=> (mem_valid && mem_is_write == $past(snoop_is_write))); // R9

endmodule

// File: rtl/snoop_reduce_wrap.sv
module snoop_reduce_wrap
  import snoop_reduce_pkg::*;
#(
  parameter int   ADDR_W      = 32,
  parameter int   ID_W        = 2,
  parameter logic [ID_W-1:0] LOCAL_ID = 2'd1,
  parameter bit   HAS_O_STATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              snoop_is_write,
  input  logic [ID_W-1:0]   snoop_src,
  input  logic              bus_shared,
  input  logic              miss_valid,
  output logic              local_snoop_valid,
  output logic [ADDR_W-1:0] local_snoop_addr,
  output logic              local_snoop_is_write,
  output logic              local_inv,
  output logic              local_shared,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_is_write
);

  red_mode_e mode_q;

  snoop_mode_capture u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .snoop_busy (snoop_valid),
    .mode_q     (mode_q)
  );

  snoop_presenter #(
    .ADDR_W      (ADDR_W),
    .ID_W        (ID_W),
    .LOCAL_ID    (LOCAL_ID),
    .HAS_O_STATE (HAS_O_STATE)
  ) u_pres (
    .clk                  (clk),
    .rst                  (rst),
    .mode_q               (mode_q),
    .snoop_valid          (snoop_valid),
    .snoop_addr           (snoop_addr),
    .snoop_is_write       (snoop_is_write),
    .snoop_src            (snoop_src),
    .local_snoop_valid    (local_snoop_valid),
    .local_snoop_addr     (local_snoop_addr),
    .local_snoop_is_write (local_snoop_is_write),
    .local_inv            (local_inv)
  );

  shared_driver u_shr (
    .clk          (clk),
    .rst          (rst),
    .mode_q       (mode_q),
    .miss_valid   (miss_valid),
    .bus_shared   (bus_shared),
    .local_shared (local_shared)
  );

  mem_forward #(.ADDR_W(ADDR_W)) u_mem (
    .clk            (clk),
    .rst            (rst),
    .snoop_valid    (snoop_valid),
    .snoop_addr     (snoop_addr),
    .snoop_is_write (snoop_is_write),
    .mem_valid      (mem_valid),
    .mem_addr       (mem_addr),
    .mem_is_write   (mem_is_write)
  );

  AST_PRESENT_ADDR_LATENCY: assert property (@(posedge clk) disable iff (rst)
    snoop_valid |=> (local_snoop_addr == $past(snoop_addr))); // R12
  AST_MSI_OWNED_CONVERTS: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && !snoop_is_write && snoop_src != LOCAL_ID && mode_q == RED_MSI)
      |=> (local_snoop_is_write == HAS_O_STATE)); // R5

endmodule

// File: tb/snoop_reduce_wrap_tb_top.sv
module snoop_reduce_wrap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 2;
  localparam logic [IW-1:0] OWN = 2'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  mode_i = 2'd0;
  logic        sv = 1'b0;
  logic [AW-1:0] sa = '0;
  logic        sw = 1'b0;
  logic [IW-1:0] ss = '0;
  logic        bsh = 1'b0;
  logic        miss = 1'b0;

  logic a_v, a_w, a_inv, a_sh, a_mv, a_mw;
  logic [AW-1:0] a_addr, a_maddr;
  logic b_v, b_w, b_inv, b_sh, b_mv, b_mw;
  logic [AW-1:0] b_addr, b_maddr;

  int tests = 0;
  int fails = 0;
  logic [1:0] mode_eff = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_reduce_wrap #(.ADDR_W(AW), .ID_W(IW), .LOCAL_ID(OWN), .HAS_O_STATE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .snoop_valid(sv), .snoop_addr(sa),
    .snoop_is_write(sw), .snoop_src(ss), .bus_shared(bsh), .miss_valid(miss),
    .local_snoop_valid(a_v), .local_snoop_addr(a_addr), .local_snoop_is_write(a_w),
    .local_inv(a_inv), .local_shared(a_sh), .mem_valid(a_mv), .mem_addr(a_maddr),
    .mem_is_write(a_mw));

  snoop_reduce_wrap #(.ADDR_W(AW), .ID_W(IW), .LOCAL_ID(OWN), .HAS_O_STATE(1'b0)) dut_plain (
    .clk(clk), .rst(rst), .mode_i(mode_i), .snoop_valid(sv), .snoop_addr(sa),
    .snoop_is_write(sw), .snoop_src(ss), .bus_shared(bsh), .miss_valid(miss),
    .local_snoop_valid(b_v), .local_snoop_addr(b_addr), .local_snoop_is_write(b_w),
    .local_inv(b_inv), .local_shared(b_sh), .mem_valid(b_mv), .mem_addr(b_maddr),
    .mem_is_write(b_mw));

  function automatic logic exp_conv(input logic [1:0] m, input logic has_o);
    return (m == 2'd0) || (m == 2'd2) || (m == 2'd1 && has_o);
  endfunction

  function automatic logic exp_shared(input logic [1:0] m, input logic mv, input logic b);
    if (!mv) return 1'b0;
    if (m == 2'd0) return 1'b0;
    if (m == 2'd1) return 1'b1;
    return b;
  endfunction

  function automatic string snoop_tag(input logic [1:0] m, input logic v, input logic w,
                                      input logic [IW-1:0] s);
    if (!v) return "R12";
    if (s == OWN) return "R10";
    if (w) return "R8";
    case (m)
      2'd0: return "R2";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic string shared_tag(input logic [1:0] m, input logic mv);
    if (!mv) return "R12";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then check the registered results
  task automatic step(input logic [1:0] m, input logic v, input logic [AW-1:0] a,
                      input logic w, input logic [IW-1:0] s, input logic b, input logic mv,
                      input string force_tag);
    logic [1:0] use_m;
    logic ev, ew, eb;
    string t;
    mode_i = m; sv = v; sa = a; sw = w; ss = s; bsh = b; miss = mv;
    use_m = mode_eff;
    @(posedge clk);
    #1;
    ev = v && (s != OWN);
    ew = ev && (w || exp_conv(use_m, 1'b1));
    eb = ev && (w || exp_conv(use_m, 1'b0));
    t  = (force_tag != "") ? force_tag : snoop_tag(use_m, v, w, s);
    chk(t, {29'd0, a_v, a_w, a_inv}, {29'd0, ev, ew, ew});
    chk(t, {30'd0, b_w, b_inv}, {30'd0, eb, eb});
    chk("R12", {16'd0, a_addr}, {16'd0, a});
    chk(shared_tag(use_m, mv), {31'd0, a_sh}, {31'd0, exp_shared(use_m, mv, b)});
    chk("R9", {14'd0, a_mv, a_mw, a_maddr}, {14'd0, v, v && w, a});
    if (!v) mode_eff = m;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; mode_i = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {26'd0, a_v, a_w, a_inv, a_sh, a_mv, a_mw}, 32'd0);
    // release reset while driving activity; first edge is still reset
    mode_i = 2'd0; sv = 1'b1; sw = 1'b1; ss = 2'd0; miss = 1'b1; bsh = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", {26'd0, a_v, a_w, a_inv, a_sh, a_mv, a_mw}, 32'd0);
    rst = 1'b0;
    mode_eff = 2'd0;

    // Directed: each mode, reads and writes, bus_shared low and high
    for (int m = 0; m < 4; m++) begin
      step(m[1:0], 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R11");
      step(m[1:0], 1'b1, 16'h1A00 + 16'(m), 1'b0, 2'd0, 1'b1, 1'b1, "");
      step(m[1:0], 1'b1, 16'h2B00 + 16'(m), 1'b0, 2'd2, 1'b0, 1'b1, "");
      step(m[1:0], 1'b1, 16'h3C00 + 16'(m), 1'b1, 2'd3, 1'b1, 1'b0, "");
      step(m[1:0], 1'b1, 16'h4D00 + 16'(m), 1'b0, OWN,  1'b0, 1'b0, "");
      step(m[1:0], 1'b0, 16'h5E00, 1'b0, 2'd0, 1'b1, 1'b1, "");
    end

    // Directed R11: mode moves to none during a snoop; snoop keeps MEI rules
    step(2'd0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R11");
    step(2'd3, 1'b1, 16'h6F00, 1'b0, 2'd2, 1'b0, 1'b0, "R11");
    step(2'd3, 1'b1, 16'h6F04, 1'b0, 2'd2, 1'b0, 1'b0, "R11");
    step(2'd3, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R11");
    step(2'd0, 1'b1, 16'h6F08, 1'b0, 2'd2, 1'b0, 1'b0, "R11");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[1:0], r[2] | r[3], r[31:16], r[4], r[6:5], r[7], r[8], "");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule